// File: doc/BRIEF.md
# Sample Capture Buffer with Byte Readout

This block records one contiguous run of converter samples into an external word memory and then streams that record out as bytes to a serial transmitter. The memory is 24 bits wide and is built from three 8-bit lanes. Its depth is two to the power `ADDR_W`, which gives 32K words at the default setting. Each sample is `SAMPLE_W` bits wide, from 12 to 20. Every write cycle places the sample at the top or at the bottom of the 24-bit word, as `lsb_just_i` selects, and fills the unused bits with zeros.

After reset the block counts out an initialisation interval and then raises `ready_o`. A start pulse begins a capture. The block writes one sample per clock at addresses 0 upward. After the last address it stops writing and raises `avail_o`. It then reads the words back in address order and offers each one as three bytes, high byte first, under a valid/ready handshake. The byte rate is set by the transmitter side, for example a 115200 baud UART. When the last byte has been accepted, `avail_o` and `ready_o` both drop. A new start pulse begins the next record.

Top module: `scb_capture_buf`

## Requirements
- R1: After reset is released, `ready_o` stays low for exactly `INIT_CYCLES` clock edges and is high from then on. `avail_o`, `tx_valid_o`, `mem_we_o` and `mem_re_o` stay low during that time.
- R2: A start pulse seen at an edge while the block is idle or finished begins a capture at that edge. From that edge on, `mem_we_o` is high for exactly 2^`ADDR_W` consecutive cycles, and `mem_addr_o` steps 0, 1, 2 and so on by one each cycle.
- R3: In a write cycle with `lsb_just_i`=0, `mem_wdata_o[23:24-SAMPLE_W]` equals `smp_i` and all lower bits are 0.
- R4: In a write cycle with `lsb_just_i`=1, `mem_wdata_o[SAMPLE_W-1:0]` equals `smp_i` and all higher bits are 0. The selection is taken anew in every write cycle.
- R5: In the cycle after the last write, `avail_o` is high and `mem_re_o` is high with `mem_raddr_o`=0. Read data is taken from `mem_rdata_i` one cycle after `mem_re_o`. `tx_valid_o` is high only while `avail_o` is high.
- R6: Each stored word is sent as three bytes: bits [23:16], then [15:8], then [7:0]. Words go out in ascending address order, and the record has 3·2^`ADDR_W` bytes in total.
- R7: A byte is transferred at an edge where `tx_valid_o` and `tx_ready_i` are both high. While `tx_ready_i` is low, `tx_valid_o` stays high and `tx_byte_o` does not change.
- R8: In the cycle after the final byte transfer, `avail_o` and `ready_o` are both low and `tx_valid_o` is low.
- R9: A start pulse during capture or readout, including at the edge of the final byte transfer, has no effect. The address sequence, the byte stream and the closing of the record are unchanged, and no write occurs while `avail_o` is high.
- R10: A start pulse after a record has been fully read out begins a new capture, and `ready_o` goes high again.
- R11: `mem_we_o` and `mem_re_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_i | input | SAMPLE_W | Converter sample |
| lsb_just_i | input | 1 | 1: place sample at bottom of word; 0: at top |
| start_i | input | 1 | Capture start command |
| tx_ready_i | input | 1 | Serial side can accept a byte |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | ADDR_W | Memory write address |
| mem_wdata_o | output | 24 | Memory write word (three byte lanes) |
| mem_re_o | output | 1 | Memory read enable |
| mem_raddr_o | output | ADDR_W | Memory read address |
| mem_rdata_i | input | 24 | Memory read word, valid one cycle after read enable |
| tx_byte_o | output | 8 | Byte offered to the serial side |
| tx_valid_o | output | 1 | `tx_byte_o` is valid |
| ready_o | output | 1 | Initialised and record not yet fully read out |
| avail_o | output | 1 | Captured record waiting or being sent |

## Verification
A start command can arrive in the same cycle as the final byte handshake. At that edge readout is still in progress, so the command must lose, and the block must still close the record. The bench holds `start_i` high through the whole readout, including that last handshake edge. It then requires `ready_o` and `avail_o` to be low one cycle later and still low, with no write, one cycle after that. The bench also raises start in the middle of the capture, and there it must see the address run continue unbroken.

// File: rtl/scb_pkg.sv
package scb_pkg;
    localparam int WORD_W = 24;
    localparam int LANE_W = 8;
    localparam int LANES  = WORD_W / LANE_W;
    localparam int IDX_W  = $clog2(LANES);

    typedef enum logic [2:0] {
        ST_INIT   = 3'd0,
        ST_IDLE   = 3'd1,
        ST_CAPT   = 3'd2,
        ST_RADDR  = 3'd3,
        ST_RLATCH = 3'd4,
        ST_SEND   = 3'd5,
        ST_DONE   = 3'd6
    } scb_state_e;
endpackage

// File: rtl/scb_packer.sv
module scb_packer
    import scb_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic                lsb_i,
    output logic [WORD_W-1:0]   word_o
);
    localparam int PAD_W = WORD_W - SAMPLE_W;

    logic [WORD_W-1:0] top_word;
    logic [WORD_W-1:0] bot_word;

    generate
        if (PAD_W > 0) begin : g_pad
            assign top_word = {sample_i, {PAD_W{1'b0}}};
            assign bot_word = {{PAD_W{1'b0}}, sample_i};
        end else begin : g_full
            assign top_word = sample_i;
            assign bot_word = sample_i;
        end
    endgenerate

    assign word_o = lsb_i ? bot_word : top_word;
endmodule

// File: rtl/scb_serializer.sv
module scb_serializer
    import scb_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  logic [IDX_W-1:0]  sel_i,
    output logic [LANE_W-1:0] byte_o
);
    logic [LANE_W-1:0] lanes [LANES];

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            assign lanes[g] = word_i[(LANES-1-g)*LANE_W +: LANE_W];
        end
    endgenerate

    always_comb begin
        byte_o = '0;
        for (int k = 0; k < LANES; k++) begin
            if (sel_i == IDX_W'(k)) byte_o = lanes[k];
        end
    end
endmodule

// File: rtl/scb_capture_buf.sv
module scb_capture_buf
    import scb_pkg::*;
#(
    parameter int ADDR_W      = 15,
    parameter int SAMPLE_W    = 16,
    parameter int INIT_CYCLES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] smp_i,
    input  logic                lsb_just_i,
    input  logic                start_i,
    input  logic                tx_ready_i,
    output logic                mem_we_o,
    output logic [ADDR_W-1:0]   mem_addr_o,
    output logic [WORD_W-1:0]   mem_wdata_o,
    output logic                mem_re_o,
    output logic [ADDR_W-1:0]   mem_raddr_o,
    input  logic [WORD_W-1:0]   mem_rdata_i,
    output logic [LANE_W-1:0]   tx_byte_o,
    output logic                tx_valid_o,
    output logic                ready_o,
    output logic                avail_o
);
    localparam int INIT_W = (INIT_CYCLES > 1) ? $clog2(INIT_CYCLES) : 1;
    localparam logic [INIT_W-1:0] INIT_LAST = INIT_W'(INIT_CYCLES - 1);
    localparam logic [IDX_W-1:0]  LANE_LAST = IDX_W'(LANES - 1);

    typedef struct packed {
        scb_state_e        state;
        logic [INIT_W-1:0] init_cnt;
        logic [ADDR_W-1:0] wr_cnt;
        logic [ADDR_W-1:0] rd_cnt;
        logic [IDX_W-1:0]  lane;
        logic [WORD_W-1:0] word;
    } scb_regs_t;

    scb_regs_t r_q, r_d;
    logic      capt_end;
    logic      rec_end;
    logic      lane_end;

    assign capt_end = &r_q.wr_cnt;
    assign rec_end  = &r_q.rd_cnt;
    assign lane_end = (r_q.lane == LANE_LAST);

    always_comb begin
        r_d        = r_q;
        mem_we_o   = 1'b0;
        mem_re_o   = 1'b0;
        tx_valid_o = 1'b0;
        case (r_q.state)
            ST_INIT: begin
                if (r_q.init_cnt == INIT_LAST) r_d.state = ST_IDLE;
                else r_d.init_cnt = r_q.init_cnt + 1'b1;
            end
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    r_d.state  = ST_CAPT;
                    r_d.wr_cnt = '0;
                end
            end
            ST_CAPT: begin
                mem_we_o = 1'b1;
                if (capt_end) begin
                    r_d.state  = ST_RADDR;
                    r_d.rd_cnt = '0;
                end else begin
                    r_d.wr_cnt = r_q.wr_cnt + 1'b1;
                end
            end
            ST_RADDR: begin
                mem_re_o  = 1'b1;
                r_d.state = ST_RLATCH;
            end
            ST_RLATCH: begin
                r_d.word  = mem_rdata_i;
                r_d.lane  = '0;
                r_d.state = ST_SEND;
            end
            ST_SEND: begin
                tx_valid_o = 1'b1;
                if (tx_ready_i) begin
                    if (!lane_end) begin
                        r_d.lane = r_q.lane + 1'b1;
                    end else if (rec_end) begin
                        r_d.state = ST_DONE;
                    end else begin
                        r_d.rd_cnt = r_q.rd_cnt + 1'b1;
                        r_d.state  = ST_RADDR;
                    end
                end
            end
            default: r_d.state = ST_INIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.state    <= ST_INIT;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_addr_o  = r_q.wr_cnt;
    assign mem_raddr_o = r_q.rd_cnt;
    assign ready_o     = (r_q.state != ST_INIT) && (r_q.state != ST_DONE);
    assign avail_o     = (r_q.state == ST_RADDR) || (r_q.state == ST_RLATCH)
                      || (r_q.state == ST_SEND);

    scb_packer #(.SAMPLE_W(SAMPLE_W)) u_pack (
        .sample_i (smp_i),
        .lsb_i    (lsb_just_i),
        .word_o   (mem_wdata_o)
    );

    scb_serializer u_ser (
        .word_i (r_q.word),
        .sel_i  (r_q.lane),
        .byte_o (tx_byte_o)
    );
endmodule

// File: rtl/scb_capture_chk.sv
module scb_capture_chk #(
    parameter int ADDR_W   = 15,
    parameter int SAMPLE_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                lsb_just_i,
    input logic                tx_ready_i,
    input logic                mem_we_o,
    input logic [ADDR_W-1:0]   mem_addr_o,
    input logic [23:0]         mem_wdata_o,
    input logic                mem_re_o,
    input logic [7:0]          tx_byte_o,
    input logic                tx_valid_o,
    input logic                ready_o,
    input logic                avail_o
);
    assert_we_re_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we_o && mem_re_o));

    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1)));

    assert_top_pad_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && !lsb_just_i) |-> (mem_wdata_o[23-SAMPLE_W:0] == '0));

    assert_bot_pad_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && lsb_just_i) |-> (mem_wdata_o[23:SAMPLE_W] == '0));

    assert_valid_in_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o |-> avail_o);

    assert_byte_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_byte_o)));

    assert_close_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(avail_o) |-> (!ready_o && !tx_valid_o));

    assert_no_write_in_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        avail_o |-> !mem_we_o);
endmodule

bind scb_capture_buf scb_capture_chk #(.ADDR_W(ADDR_W), .SAMPLE_W(SAMPLE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lsb_just_i  (lsb_just_i),
    .tx_ready_i  (tx_ready_i),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_re_o    (mem_re_o),
    .tx_byte_o   (tx_byte_o),
    .tx_valid_o  (tx_valid_o),
    .ready_o     (ready_o),
    .avail_o     (avail_o)
);

// File: tb/scb_capture_buf_tb.sv
module scb_capture_buf_tb;
    localparam int AW    = 4;
    localparam int SW    = 18;
    localparam int INITC = 4;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [SW-1:0] smp_i = '0;
    logic          lsb_just_i = 1'b0;
    logic          start_i = 1'b0;
    logic          tx_ready_i = 1'b0;
    logic          mem_we_o, mem_re_o, tx_valid_o, ready_o, avail_o;
    logic [AW-1:0] mem_addr_o, mem_raddr_o;
    logic [23:0]   mem_wdata_o;
    logic [23:0]   mem_rdata_i = '0;
    logic [7:0]    tx_byte_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [23:0] mem [DEPTH];
    logic [23:0] exp_word [DEPTH];
    logic [7:0]  byte_log [512];
    int          byte_n = 0;

    always #2.5 clk = ~clk;

    scb_capture_buf #(.ADDR_W(AW), .SAMPLE_W(SW), .INIT_CYCLES(INITC)) u_dut (
        .clk(clk), .rst_n(rst_n), .smp_i(smp_i), .lsb_just_i(lsb_just_i),
        .start_i(start_i), .tx_ready_i(tx_ready_i), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_re_o(mem_re_o),
        .mem_raddr_o(mem_raddr_o), .mem_rdata_i(mem_rdata_i), .tx_byte_o(tx_byte_o),
        .tx_valid_o(tx_valid_o), .ready_o(ready_o), .avail_o(avail_o)
    );

    // external memory and serial sink models
    always @(posedge clk) begin
        if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
        if (mem_re_o) mem_rdata_i <= mem[mem_raddr_o];
        if (tx_valid_o && tx_ready_i && byte_n < 512) begin
            byte_log[byte_n] <= tx_byte_o;
            byte_n <= byte_n + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [SW-1:0] smp_val(input int run, input int i);
        if (i == 0) return '1;
        if (i == 1) return '0;
        return SW'((i * 40503 + run * 9973) ^ (i << 9));
    endfunction

    function automatic logic [23:0] pack_exp(input logic [SW-1:0] v, input bit lsb);
        logic [23:0] w;
        w = 24'(v);
        return lsb ? w : (w << (24 - SW));
    endfunction

    function automatic bit rdy_pat(input int mode, input int c);
        case (mode)
            0: return ((c * 7) % 5) < 3;
            1: return 1'b1;
            default: return (c % 4) == 3;
        endcase
    endfunction

    // lsb_mode: 0 top, 1 bottom, 2 alternate per word
    task automatic do_run(input int run, input int lsb_mode, input int rdy_mode);
        int  base;
        bit  pend;
        logic [7:0] pbyte;
        int  cyc;
        string jtag;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R10 ready high after start", 32'(ready_o), 1);
        for (int i = 0; i < DEPTH; i++) begin
            bit lsb;
            lsb = (lsb_mode == 2) ? i[0] : (lsb_mode == 1);
            smp_i = smp_val(run, i);
            lsb_just_i = lsb;
            exp_word[i] = pack_exp(smp_i, lsb);
            start_i = (i == 5);  // R9: ignored during capture
            chk("R2 write enable", 32'(mem_we_o), 1);
            chk("R2 R9 write address", 32'(mem_addr_o), i);
            chk("R11 no read in capture", 32'(mem_re_o), 0);
            @(negedge clk);
        end
        start_i = 1'b0;
        chk("R5 avail after capture", 32'(avail_o), 1);
        chk("R5 read enable", 32'(mem_re_o), 1);
        chk("R5 read address 0", 32'(mem_raddr_o), 0);
        chk("R2 write stops", 32'(mem_we_o), 0);
        for (int i = 0; i < DEPTH; i++) begin
            jtag = (lsb_mode == 0) ? "R3 stored word" : "R4 stored word";
            chk(jtag, mem[i], exp_word[i]);
        end
        base = byte_n;
        pend = 1'b0;
        pbyte = '0;
        cyc = 0;
        start_i = 1'b1;  // R9: held through readout, including the final handshake
        while (avail_o && cyc < 4000) begin
            tx_ready_i = rdy_pat(rdy_mode, cyc);
            pend = tx_valid_o && !tx_ready_i;
            pbyte = tx_byte_o;
            @(negedge clk);
            cyc++;
            if (pend) begin
                chk("R7 valid held", 32'(tx_valid_o), 1);
                chk("R7 byte held", 32'(tx_byte_o), 32'(pbyte));
            end
            if (mem_we_o) chk("R9 no write during readout", 32'(mem_we_o), 0);
            if (tx_valid_o && !avail_o) chk("R5 valid within avail", 32'(avail_o), 1);
        end
        start_i = 1'b0;
        tx_ready_i = 1'b0;
        chk("R8 ready low at close", 32'(ready_o), 0);
        chk("R8 avail low at close", 32'(avail_o), 0);
        chk("R8 valid low at close", 32'(tx_valid_o), 0);
        @(negedge clk);
        chk("R9 start at last handshake ignored", 32'(ready_o), 0);
        chk("R9 no write after close", 32'(mem_we_o), 0);
        chk("R6 byte count", byte_n - base, 3 * DEPTH);
        for (int w = 0; w < DEPTH; w++) begin
            for (int k = 0; k < 3; k++) begin
                logic [7:0] eb;
                eb = 8'(exp_word[w] >> (16 - 8 * k));
                chk("R6 byte order", 32'(byte_log[base + 3 * w + k]), 32'(eb));
            end
        end
    endtask

    initial begin
        int k;
        repeat (3) @(negedge clk);
        chk("R1 ready low in reset", 32'(ready_o), 0);
        rst_n = 1'b1;
        start_i = 1'b1;  // ignored during initialisation
        k = 0;
        while (!ready_o && k < 50) begin
            @(negedge clk);
            k++;
            if (!ready_o) begin
                chk("R1 no write in init", 32'(mem_we_o), 0);
                chk("R1 no avail in init", 32'(avail_o), 0);
                chk("R1 no valid in init", 32'(tx_valid_o), 0);
            end
        end
        start_i = 1'b0;
        chk("R1 init length", k, INITC);
        @(negedge clk);
        chk("R1 ready stays high", 32'(ready_o), 1);
        chk("R1 no capture without start", 32'(mem_we_o), 0);
        do_run(1, 0, 0);
        do_run(2, 1, 1);
        do_run(3, 2, 2);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule